// File: doc/BRIEF.md
# Flash Program/Erase Permission Gate

This block sits between the command decoder of a flash memory controller and the engine that runs program and erase operations. For every program, sector-erase or chip-erase request it decides, in one registered cycle, whether the operation may start, must be refused, or is simply not a real write cycle and is dropped. The decision combines a digital supply-good flag, a power-on holdoff counted in clock cycles, a minimum-width qualification of the write strobes, and a boot-sector lockout that a high-voltage override input can defeat.

The memory is split into four erase sectors: a boot sector, two parameter sectors and a main sector. A parameter chooses whether the boot sector sits at the bottom or at the top of the address space; the parameter sectors sit next to it and the main sector fills the rest. On a granted request the gate emits a sector mask telling the engine which sectors the operation touches, and it tracks the operation until the engine reports completion. When a boot-sector operation was only allowed because of the override, releasing the override before completion aborts it.

Top module: `flash_wr_guard`

## Requirements
- R1: A request sampled while `supply_ok` is 0 is never granted; if it is otherwise a valid write cycle it is rejected.
- R2: A grant needs `supply_ok` to have been 1 on at least `HOLD_CYC` consecutive clock edges before the edge at which the request is sampled; a low supply restarts this count. A qualified request made earlier is rejected.
- R3: A request counts only if the write state (`cs_n`=0, `we_n`=0, `oe_n`=1) is present at the sampling edge and was present on the `MIN_W` edges before it; otherwise, and while an operation is active, the request is ignored: no grant and no reject.
- R4: `sect_mask` bit 0 is the boot sector, bit 1 the parameter sector next to it, bit 2 the other parameter sector, bit 3 the main sector. With bottom boot, word addresses below `BOOT_WORDS` are boot, the next `PARAM_WORDS` are bit 1, the next `PARAM_WORDS` bit 2; with top boot the same layout counts down from the highest address. A granted program or sector erase carries the one-hot mask of its target sector.
- R5: With `lock_en`=1 and `hv_ovr`=0, a program (`req_kind`=00) or sector erase (01) aimed at the boot sector is rejected.
- R6: A chip erase (`req_kind`=10) is granted with mask 1110 when `lock_en`=1 and `hv_ovr`=0, and with mask 1111 otherwise.
- R7: With `hv_ovr`=1 a boot-sector operation is granted despite the lockout; if `hv_ovr` falls while such an operation is active, `abort` pulses for one cycle and the operation ends, and later boot requests without the override are rejected again.
- R8: `grant`, `reject` and `abort` are registered one-cycle pulses, never two at once, appearing in the cycle after the request is sampled; `sect_mask` is zero except with `grant`; the reserved kind 11 is rejected.
- R9: `op_active` rises with `grant` and falls the cycle after `op_done`; when `op_done` and the release of `hv_ovr` fall in the same cycle, the operation completes and no abort is raised.
- R10: During and right after reset all outputs are 0 and the power-on holdoff starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Digital supply-good indication |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lock_en | input | 1 | Boot-sector lockout enabled |
| hv_ovr | input | 1 | High-voltage override of the lockout |
| req_valid | input | 1 | Request from the command decoder |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | ADDR_W | Target word address |
| op_done | input | 1 | Operation engine reports completion |
| grant | output | 1 | One-cycle start permission |
| reject | output | 1 | One-cycle refusal |
| abort | output | 1 | One-cycle abort of an overridden boot operation |
| op_active | output | 1 | Operation in progress |
| sect_mask | output | 4 | Sectors touched by the granted operation |

## Verification
Completion from the engine and release of the override can land on the same clock edge while an overridden boot-sector operation runs; the bench grants a boot sector erase with the override held, then drives `op_done` high and `hv_ovr` low on the same falling edge. It judges the result one cycle later: `op_active` must be 0 and `abort` must stay 0, because completion takes priority. A second instance built for top boot sees the same stimulus, so every address in the vector table is judged against both layouts.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_SERASE = 2'b01,
      OP_CHIP   = 2'b10,
      OP_RSVD   = 2'b11
   } op_kind_e;

   localparam int NSECT  = 4;
   localparam int S_BOOT = 0;
   localparam int S_PA   = 1;
   localparam int S_PB   = 2;
   localparam int S_MAIN = 3;
endpackage

// File: rtl/fwg_strobe_filter.sv
module fwg_strobe_filter #(
   parameter int MIN_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic oe_n,
   input  logic we_n,
   output logic qual
);
   localparam int CW = $clog2(MIN_W + 1);

   logic          wr_state;
   logic [CW-1:0] run_q;

   assign wr_state = !cs_n && !we_n && oe_n;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (!wr_state)
         run_q <= '0;
      else if (run_q < CW'(MIN_W))
         run_q <= run_q + 1'b1;
   end

   assign qual = wr_state && (run_q >= CW'(MIN_W));
endmodule

// File: rtl/fwg_power_hold.sv
module fwg_power_hold #(
   parameter int HOLD_CYC = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic ready
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else if (!supply_ok)
         hold_q <= '0;
      else if (hold_q < HW'(HOLD_CYC))
         hold_q <= hold_q + 1'b1;
   end

   assign ready = (hold_q == HW'(HOLD_CYC));
endmodule

// File: rtl/fwg_sector_decode.sv
module fwg_sector_decode
   import fwg_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int BOOT_WORDS  = 8192,
   parameter int PARAM_WORDS = 4096,
   parameter int TOP_BOOT    = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NSECT-1:0]  hit
);
   localparam logic [ADDR_W:0] LIM_BOOT = (ADDR_W+1)'(BOOT_WORDS);
   localparam logic [ADDR_W:0] LIM_PA   = (ADDR_W+1)'(BOOT_WORDS + PARAM_WORDS);
   localparam logic [ADDR_W:0] LIM_PB   = (ADDR_W+1)'(BOOT_WORDS + 2*PARAM_WORDS);

   logic [ADDR_W-1:0] off;

   generate
      if (TOP_BOOT != 0) begin : g_top
         assign off = ~addr;
      end else begin : g_bottom
         assign off = addr;
      end
   endgenerate

   always_comb begin
      hit = '0;
      if ({1'b0, off} < LIM_BOOT)
         hit[S_BOOT] = 1'b1;
      else if ({1'b0, off} < LIM_PA)
         hit[S_PA] = 1'b1;
      else if ({1'b0, off} < LIM_PB)
         hit[S_PB] = 1'b1;
      else
         hit[S_MAIN] = 1'b1;
   end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
   import fwg_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int BOOT_WORDS  = 8192,
   parameter int PARAM_WORDS = 4096,
   parameter int TOP_BOOT    = 0,
   parameter int MIN_W       = 3,
   parameter int HOLD_CYC    = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              lock_en,
   input  logic              hv_ovr,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              op_done,
   output logic              grant,
   output logic              reject,
   output logic              abort,
   output logic              op_active,
   output logic [NSECT-1:0]  sect_mask
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (MIN_W < 1) begin : g_bad_minw
         $error("MIN_W must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("HOLD_CYC must be at least 1");
      end
      if (BOOT_WORDS + 2*PARAM_WORDS >= DEPTH) begin : g_bad_map
         $error("boot and parameter sectors leave no main sector");
      end
      if (TOP_BOOT != 0 && TOP_BOOT != 1) begin : g_bad_top
         $error("TOP_BOOT must be 0 or 1");
      end
   endgenerate

   logic             strobe_ok;
   logic             pwr_ready;
   logic [NSECT-1:0] tgt;
   logic             needs_ovr_q;

   logic             d_grant;
   logic             d_reject;
   logic [NSECT-1:0] d_mask;
   logic             d_needs;

   fwg_strobe_filter #(.MIN_W(MIN_W)) u_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .oe_n  (oe_n),
      .we_n  (we_n),
      .qual  (strobe_ok)
   );

   fwg_power_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .supply_ok (supply_ok),
      .ready     (pwr_ready)
   );

   fwg_sector_decode #(
      .ADDR_W      (ADDR_W),
      .BOOT_WORDS  (BOOT_WORDS),
      .PARAM_WORDS (PARAM_WORDS),
      .TOP_BOOT    (TOP_BOOT)
   ) u_decode (
      .addr (req_addr),
      .hit  (tgt)
   );

   logic take;
   logic pwr_ok;
   logic locked;

   assign take   = req_valid && strobe_ok && !op_active;
   assign pwr_ok = supply_ok && pwr_ready;
   assign locked = lock_en && !hv_ovr;

   always_comb begin
      d_grant  = 1'b0;
      d_reject = 1'b0;
      d_mask   = '0;
      d_needs  = 1'b0;
      if (take) begin
         case (op_kind_e'(req_kind))
            OP_PROG, OP_SERASE: begin
               if (!pwr_ok || (tgt[S_BOOT] && locked)) begin
                  d_reject = 1'b1;
               end else begin
                  d_grant = 1'b1;
                  d_mask  = tgt;
                  d_needs = tgt[S_BOOT] && lock_en;
               end
            end
            OP_CHIP: begin
               if (!pwr_ok) begin
                  d_reject = 1'b1;
               end else begin
                  d_grant = 1'b1;
                  d_mask  = '1;
                  if (locked)
                     d_mask[S_BOOT] = 1'b0;
                  d_needs = lock_en && hv_ovr;
               end
            end
            default: d_reject = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant       <= 1'b0;
         reject      <= 1'b0;
         abort       <= 1'b0;
         op_active   <= 1'b0;
         needs_ovr_q <= 1'b0;
         sect_mask   <= '0;
      end else begin
         grant     <= d_grant;
         reject    <= d_reject;
         sect_mask <= d_grant ? d_mask : '0;
         abort     <= 1'b0;
         if (op_active) begin
            if (op_done) begin
               op_active   <= 1'b0;
               needs_ovr_q <= 1'b0;
            end else if (needs_ovr_q && !hv_ovr) begin
               abort       <= 1'b1;
               op_active   <= 1'b0;
               needs_ovr_q <= 1'b0;
            end
         end else if (d_grant) begin
            op_active   <= 1'b1;
            needs_ovr_q <= d_needs;
         end
      end
   end
endmodule

// File: rtl/fwg_checker.sv
module fwg_checker
   import fwg_pkg::*;
#(
   parameter int HOLD_CYC = 1_000_000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             supply_ok,
   input logic             cs_n,
   input logic             oe_n,
   input logic             we_n,
   input logic             lock_en,
   input logic             hv_ovr,
   input logic [1:0]       req_kind,
   input logic             op_done,
   input logic             grant,
   input logic             reject,
   input logic             abort,
   input logic             op_active,
   input logic [NSECT-1:0] sect_mask
);
   localparam int GW = $clog2(HOLD_CYC + 1);

   logic [GW-1:0] good_run;

   always_ff @(posedge clk) begin
      if (!rst_n)
         good_run <= '0;
      else if (!supply_ok)
         good_run <= '0;
      else if (good_run < GW'(HOLD_CYC))
         good_run <= good_run + 1'b1;
   end

   assert_no_grant_low_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !grant);

   assert_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> $past(good_run == GW'(HOLD_CYC)));

   assert_write_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> $past(!cs_n && !we_n && oe_n));

   assert_onehot_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && $past(req_kind != OP_CHIP)) |-> ($countones(sect_mask) == 1));

   assert_boot_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && $past(lock_en && !hv_ovr)) |-> !sect_mask[S_BOOT]);

   assert_chip_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && $past(req_kind == OP_CHIP)) |-> (sect_mask[NSECT-1:1] == '1));

   assert_abort_ends_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> ($past(op_active) && !op_active));

   assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, reject, abort}));

   assert_mask_only_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |-> (sect_mask == '0));

   assert_grant_starts_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> op_active);

   assert_done_beats_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_active && op_done) |-> (!abort && !op_active));
endmodule

bind flash_wr_guard fwg_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .supply_ok (supply_ok),
   .cs_n      (cs_n),
   .oe_n      (oe_n),
   .we_n      (we_n),
   .lock_en   (lock_en),
   .hv_ovr    (hv_ovr),
   .req_kind  (req_kind),
   .op_done   (op_done),
   .grant     (grant),
   .reject    (reject),
   .abort     (abort),
   .op_active (op_active),
   .sect_mask (sect_mask)
);

// File: tb/flash_wr_guard_tb.sv
module flash_wr_guard_tb;
   localparam int AW   = 19;
   localparam int MINW = 3;
   localparam int HOLD = 20;
   localparam int NV   = 16;
   localparam int VW   = 2 + AW + 2 + 6 + 6;

   // kind, addr, lock, ovr, expected {grant,reject,mask} bottom, then top
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'b00, 19'h00010, 1'b0, 1'b0, 6'b10_0001, 6'b10_1000},
      {2'b00, 19'h00010, 1'b1, 1'b0, 6'b01_0000, 6'b10_1000},
      {2'b00, 19'h7F000, 1'b1, 1'b0, 6'b10_1000, 6'b01_0000},
      {2'b00, 19'h7F000, 1'b1, 1'b1, 6'b10_1000, 6'b10_0001},
      {2'b01, 19'h02800, 1'b1, 1'b0, 6'b10_0010, 6'b10_1000},
      {2'b01, 19'h03FFF, 1'b1, 1'b0, 6'b10_0100, 6'b10_1000},
      {2'b01, 19'h7D000, 1'b0, 1'b0, 6'b10_1000, 6'b10_0010},
      {2'b01, 19'h7C000, 1'b0, 1'b0, 6'b10_1000, 6'b10_0100},
      {2'b10, 19'h00000, 1'b1, 1'b0, 6'b10_1110, 6'b10_1110},
      {2'b10, 19'h00000, 1'b0, 1'b0, 6'b10_1111, 6'b10_1111},
      {2'b10, 19'h00000, 1'b1, 1'b1, 6'b10_1111, 6'b10_1111},
      {2'b11, 19'h40000, 1'b0, 1'b0, 6'b01_0000, 6'b01_0000},
      {2'b01, 19'h01FFF, 1'b1, 1'b0, 6'b01_0000, 6'b10_1000},
      {2'b01, 19'h7DFFF, 1'b1, 1'b0, 6'b10_1000, 6'b10_0010},
      {2'b00, 19'h7E000, 1'b1, 1'b0, 6'b10_1000, 6'b01_0000},
      {2'b00, 19'h02000, 1'b1, 1'b0, 6'b10_0010, 6'b10_1000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          supply_ok = 1'b1;
   logic          cs_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          we_n = 1'b1;
   logic          lock_en = 1'b0;
   logic          hv_ovr = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic          op_done = 1'b0;

   logic       g_b, r_b, a_b, act_b;
   logic [3:0] m_b;
   logic       g_t, r_t, a_t, act_t;
   logic [3:0] m_t;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   flash_wr_guard #(.ADDR_W(AW), .TOP_BOOT(0), .MIN_W(MINW), .HOLD_CYC(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .oe_n(oe_n),
      .we_n(we_n), .lock_en(lock_en), .hv_ovr(hv_ovr), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .op_done(op_done),
      .grant(g_b), .reject(r_b), .abort(a_b), .op_active(act_b), .sect_mask(m_b)
   );

   flash_wr_guard #(.ADDR_W(AW), .TOP_BOOT(1), .MIN_W(MINW), .HOLD_CYC(HOLD)) u_dut_top (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .oe_n(oe_n),
      .we_n(we_n), .lock_en(lock_en), .hv_ovr(hv_ovr), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .op_done(op_done),
      .grant(g_t), .reject(r_t), .abort(a_t), .op_active(act_t), .sect_mask(m_t)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // hold = number of edges the write state is held before the sampling edge
   task automatic try_req(input logic [1:0] kind, input logic [AW-1:0] addr,
                          input int hold, input logic oe_lvl);
      cs_n = 1'b0;
      we_n = 1'b0;
      oe_n = oe_lvl;
      repeat (hold) @(negedge clk);
      req_valid = 1'b1;
      req_kind  = kind;
      req_addr  = addr;
      @(negedge clk);
      req_valid = 1'b0;
      cs_n = 1'b1;
      we_n = 1'b1;
      oe_n = 1'b1;
   endtask

   task automatic finish_op;
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {1'b0, g_b, r_b, a_b, m_b}, 8'h00);
      chk("R10 reset active", {7'b0, act_b}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after reset", {g_b, r_b, a_b, act_b, m_b}, 8'h00);

      // R2: holdoff not yet elapsed
      try_req(2'b00, 19'h40000, MINW, 1'b1);
      chk("R2 early request rejected", {2'b0, g_b, r_b, m_b}, 8'b0001_0000);
      repeat (HOLD + 5) @(negedge clk);
      try_req(2'b00, 19'h40000, MINW, 1'b1);
      chk("R2 after holdoff granted", {2'b0, g_b, r_b, m_b}, 8'b0010_1000);
      finish_op();
      chk("R9 op ends after done", {7'b0, act_b}, 8'h00);

      // R1: low supply
      supply_ok = 1'b0;
      try_req(2'b00, 19'h40000, MINW, 1'b1);
      chk("R1 low supply rejected", {2'b0, g_b, r_b, m_b}, 8'b0001_0000);
      supply_ok = 1'b1;
      try_req(2'b00, 19'h40000, MINW, 1'b1);
      chk("R2 holdoff restarts", {2'b0, g_b, r_b, m_b}, 8'b0001_0000);
      repeat (HOLD + 5) @(negedge clk);

      // vector table: R4 R5 R6 R8 on both layouts
      for (int i = 0; i < NV; i++) begin
         lock_en = VEC[i][13];
         hv_ovr  = VEC[i][12];
         try_req(VEC[i][VW-1 -: 2], VEC[i][VW-3 -: AW], MINW, 1'b1);
         chk($sformatf("R4 R5 R6 R8 bottom vec %0d", i), {2'b0, g_b, r_b, m_b}, {2'b0, VEC[i][11:6]});
         chk($sformatf("R4 R5 R6 R8 top vec %0d", i), {2'b0, g_t, r_t, m_t}, {2'b0, VEC[i][5:0]});
         @(negedge clk);
         chk($sformatf("R8 single pulse vec %0d", i), {6'b0, g_b | g_t, r_b | r_t}, 8'h00);
         finish_op();
      end

      // R3: short strobe and output-enable low are ignored
      lock_en = 1'b0;
      hv_ovr  = 1'b0;
      try_req(2'b00, 19'h40000, MINW - 1, 1'b1);
      chk("R3 short strobe ignored", {4'b0, g_b, r_b, g_t, r_t}, 8'h00);
      try_req(2'b00, 19'h40000, MINW + 2, 1'b0);
      chk("R3 oe low ignored", {4'b0, g_b, r_b, g_t, r_t}, 8'h00);
      chk("R3 no op started", {6'b0, act_b, act_t}, 8'h00);

      // R3/R9: request while busy is ignored
      try_req(2'b00, 19'h50000, MINW, 1'b1);
      chk("R9 grant sets active", {6'b0, act_b, g_b}, 8'h03);
      try_req(2'b01, 19'h60000, MINW, 1'b1);
      chk("R3 busy request ignored", {4'b0, g_b, r_b, act_b, act_t}, 8'h03);
      finish_op();

      // R7: override released mid-operation aborts
      lock_en = 1'b1;
      hv_ovr  = 1'b1;
      try_req(2'b00, 19'h00100, MINW, 1'b1);
      chk("R7 override grants boot", {2'b0, g_b, r_b, m_b}, 8'b0010_0001);
      hv_ovr = 1'b0;
      @(negedge clk);
      chk("R7 abort pulse", {5'b0, a_b, act_b, a_t}, 8'b0000_0100);
      chk("R7 top op unaffected", {7'b0, act_t}, 8'h01);
      @(negedge clk);
      chk("R8 abort one cycle", {7'b0, a_b}, 8'h00);
      finish_op();
      try_req(2'b00, 19'h00100, MINW, 1'b1);
      chk("R7 lockout back", {2'b0, g_b, r_b, m_b}, 8'b0001_0000);
      finish_op();

      // R9: done and override release in the same cycle
      hv_ovr = 1'b1;
      try_req(2'b01, 19'h01000, MINW, 1'b1);
      chk("R9 boot erase granted", {2'b0, g_b, r_b, m_b}, 8'b0010_0001);
      op_done = 1'b1;
      hv_ovr  = 1'b0;
      @(negedge clk);
      op_done = 1'b0;
      chk("R9 done beats release", {6'b0, a_b, act_b}, 8'h00);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule